// File: doc/BRIEF.md
# Net Transition Tester

This block checks one already-configured two-point routing path between a source flip-flop and a sink flip-flop. A configuration loader hands it a start pulse and a settle time. The block then runs a fixed five-step drive and capture sequence. First it forces the source low. It then raises the source and samples the sink. Finally it lowers the source and samples the sink again. The path is judged good only if the sink followed both the rising and the falling edge.

The block has no knowledge of the switches along the path. It drives one value bit towards the source flip-flop, pulses a capture strobe when the sink flip-flop's value is to be read, and takes that value back on a single input. At the end it raises a one-cycle done flag together with a pass bit. The loader uses that bit to keep the path or to swap in another candidate route.

Top module: `net_transition_tester`

## Requirements
- R1: After reset, and whenever no test is running, busy_o, drive_o, capture_o, done_o and pass_o are all 0.
- R2: The rising edge of clk_i that samples start_i high while idle begins step 1. For the next S+1 cycles drive_o is 0 and capture_o is 0, where S is the settle value.
- R3: Steps 2 and 3 follow. drive_o is 1 for S+1 cycles, and then for one further cycle, in which capture_o is 1 and sink_i is sampled as the rising-edge result.
- R4: Steps 4 and 5 follow. drive_o is 0 for S+1 cycles, then for one further cycle, in which capture_o is 1 and sink_i is sampled as the falling-edge result.
- R5: done_o is 1 for exactly one cycle. That cycle is reached 3*(S+1)+2 rising edges after the edge that accepted start_i. The block is idle in the following cycle and can accept a new start_i there.
- R6: In the done cycle, pass_o is 1 only if sink_i was 1 at the step-3 capture and 0 at the step-5 capture. pass_o is 0 in every cycle in which done_o is 0.
- R7: busy_o is 1 from the cycle after start_i is accepted through the done cycle. start_i has no effect while busy_o is 1.
- R8: The settle value is taken from settle_cycles_i on the edge that accepts start_i. Later changes of settle_cycles_i do not alter the running test.
- R9: A settle value of 0 gives the shortest test, with one cycle per drive step and done_o 5 edges after the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to test the path; taken only when idle |
| settle_cycles_i | input | SETTLE_W | Extra cycles (S) each drive step holds before moving on |
| sink_i | input | 1 | Value read back from the sink flip-flop |
| drive_o | output | 1 | Value to load into the source flip-flop |
| capture_o | output | 1 | Strobe: sink_i is sampled in this cycle |
| busy_o | output | 1 | A test is in progress |
| done_o | output | 1 | One-cycle end-of-test flag |
| pass_o | output | 1 | Test verdict, valid only while done_o is 1 |

## Verification
Every output follows from the position k of the current cycle after the start edge, with L = S+1. drive_o is 1 for k in [L, 2L]. The capture strobes fall at k = 2L and k = 3L+1. done_o is due at k = 3L+2. The bench keeps the start cycle and the settle value of each accepted request and derives all five outputs from k in every cycle. It compares them half a period after the edge, so each register stage is already counted. The sink is a bench-side path model with a selectable delay or a stuck value. The verdict expected in the done cycle is therefore built from the sink values the bench itself presented at the two capture cycles. A fixed expected verdict per scenario cross-checks it.

// File: rtl/ntt_pkg.sv
package ntt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FORCE_LO,
    ST_RISE,
    ST_CAP_HI,
    ST_FALL,
    ST_CAP_LO,
    ST_DONE
  } step_e;
endpackage

// File: rtl/ntt_settle_timer.sv
module ntt_settle_timer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] value_i,
  output logic             expired_o
);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= value_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ntt_step_seq.sv
module ntt_step_seq
  import ntt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  expired_i,
  output step_e step_o,
  output logic  load_o
);
  step_e step_q, step_d;

  always_comb begin
    step_d = step_q;
    load_o = 1'b0;
    unique case (step_q)
      ST_IDLE:     if (start_i)   begin step_d = ST_FORCE_LO; load_o = 1'b1; end
      ST_FORCE_LO: if (expired_i) begin step_d = ST_RISE;     load_o = 1'b1; end
      ST_RISE:     if (expired_i) step_d = ST_CAP_HI;
      ST_CAP_HI:   begin step_d = ST_FALL; load_o = 1'b1; end
      ST_FALL:     if (expired_i) step_d = ST_CAP_LO;
      ST_CAP_LO:   step_d = ST_DONE;
      ST_DONE:     step_d = ST_IDLE;
      default:     step_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= ST_IDLE;
    else         step_q <= step_d;
  end

  assign step_o = step_q;
endmodule

// File: rtl/ntt_verdict.sv
module ntt_verdict
  import ntt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  step_e step_i,
  input  logic  sink_i,
  output logic  pass_o
);
  logic rise_ok_q, fall_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_ok_q <= 1'b0;
      fall_ok_q <= 1'b0;
    end else begin
      if (step_i == ST_CAP_HI) rise_ok_q <= sink_i;
      if (step_i == ST_CAP_LO) fall_ok_q <= ~sink_i;
    end
  end

  assign pass_o = (step_i == ST_DONE) & rise_ok_q & fall_ok_q;
endmodule

// File: rtl/net_transition_tester.sv
module net_transition_tester
  import ntt_pkg::*;
#(
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  input  logic                sink_i,
  output logic                drive_o,
  output logic                capture_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                pass_o
);
  step_e               step;
  logic                load, expired;
  logic [SETTLE_W-1:0] settle_q, timer_val;

  // settle value frozen for the whole test
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          settle_q <= '0;
    else if (step == ST_IDLE && start_i)  settle_q <= settle_cycles_i;
  end

  assign timer_val = (step == ST_IDLE) ? settle_cycles_i : settle_q;

  ntt_settle_timer #(.WIDTH(SETTLE_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .value_i   (timer_val),
    .expired_o (expired)
  );

  ntt_step_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .expired_i (expired),
    .step_o    (step),
    .load_o    (load)
  );

  ntt_verdict u_verdict (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .sink_i (sink_i),
    .pass_o (pass_o)
  );

  assign drive_o   = (step == ST_RISE) || (step == ST_CAP_HI);
  assign capture_o = (step == ST_CAP_HI) || (step == ST_CAP_LO);
  assign busy_o    = (step != ST_IDLE);
  assign done_o    = (step == ST_DONE);
endmodule

// File: rtl/ntt_checker.sv
module ntt_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_i,
  input logic drive_i,
  input logic capture_i,
  input logic done_i,
  input logic pass_i
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!drive_i && !capture_i && !done_i));

  // R3/R4: the driven value has settled before each capture
  p_cap_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> $stable(drive_i));

  p_cap_in_test_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> (busy_i && !done_i));

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (!done_i && !busy_i));

  p_cap_then_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capture_i && !drive_i) |=> done_i);

  p_pass_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> !pass_i);

  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !done_i) |=> busy_i);
endmodule

bind net_transition_tester ntt_checker u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy_o),
  .drive_i   (drive_o),
  .capture_i (capture_o),
  .done_i    (done_o),
  .pass_i    (pass_o)
);

// File: tb/net_transition_tester_tb.sv
module net_transition_tester_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [SW-1:0] settle_cycles_i = '0;
  logic          sink_i;
  logic          drive_o, capture_o, busy_o, done_o, pass_o;

  net_transition_tester #(.SETTLE_W(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .settle_cycles_i(settle_cycles_i), .sink_i(sink_i),
    .drive_o(drive_o), .capture_o(capture_o), .busy_o(busy_o),
    .done_o(done_o), .pass_o(pass_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // path model: 0 = good with delay, 1 = stuck low, 2 = stuck high
  int         fault_mode = 0;
  int         path_delay = 1;
  logic [3:0] pipe = '0;
  always @(posedge clk) pipe <= {pipe[2:0], drive_o};
  always_comb begin
    case (fault_mode)
      1:       sink_i = 1'b0;
      2:       sink_i = 1'b1;
      default: sink_i = pipe[path_delay-1];
    endcase
  end

  int vectors = 0, errors = 0, cyc = 0;
  bit m_act = 0, m_hi = 0, m_lo = 0;
  int t0 = 0, m_s = 0;

  task automatic cmp(input string tag, input string nm, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0b exp=%0b cycle=%0d", tag, nm, act, exp, cyc);
    end
  endtask

  // reference model, compared every cycle
  always @(negedge clk) begin
    if (rst_ni) begin
      int k, L;
      bit e_busy, e_drv, e_cap, e_done, e_pass;
      string tag;
      k = cyc - t0 - 1;
      L = m_s + 1;
      e_busy = m_act;
      e_drv  = m_act && k >= L && k <= 2*L;
      e_cap  = m_act && (k == 2*L || k == 3*L+1);
      e_done = m_act && k == 3*L+2;
      e_pass = e_done && m_hi && m_lo;
      if (!m_act)          tag = "R1";
      else if (k < L)      tag = "R2";
      else if (k <= 2*L)   tag = "R3";
      else if (k <= 3*L+1) tag = "R4";
      else                 tag = "R5";
      cmp(tag,  "drive_o",   drive_o,   e_drv);
      cmp(tag,  "capture_o", capture_o, e_cap);
      cmp("R7", "busy_o",    busy_o,    e_busy);
      cmp(tag,  "done_o",    done_o,    e_done);
      cmp("R6", "pass_o",    pass_o,    e_pass);
      if (m_act && k == 2*L)   m_hi = sink_i;
      if (m_act && k == 3*L+1) m_lo = !sink_i;
      if (e_done) m_act = 0;
      if (!e_busy && start_i) begin
        m_act = 1; t0 = cyc; m_s = int'(settle_cycles_i);
      end
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic run_test(input int s, input int mode, input int dly,
                          input bit exp_pass, input bit poke, input string tag);
    @(posedge clk); #1;
    fault_mode = mode; path_delay = dly;
    settle_cycles_i = SW'(s);
    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (poke) begin
      // R7/R8: restart attempt and settle change mid-test must do nothing
      @(posedge clk); #1;
      start_i = 1'b1;
      settle_cycles_i = SW'(s + 5);
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    do @(negedge clk); while (!done_o);
    cmp(tag, "verdict", pass_o, exp_pass);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    repeat (3) @(posedge clk);
    run_test(0, 0, 1, 1'b1, 1'b0, "R9");  // shortest test, good path
    run_test(3, 0, 4, 1'b1, 1'b0, "R6");  // slow path, enough settle
    run_test(0, 0, 4, 1'b0, 1'b0, "R6");  // slow path, too little settle
    run_test(2, 1, 1, 1'b0, 1'b0, "R3");  // stuck low fails rising check
    run_test(2, 2, 1, 1'b0, 1'b0, "R4");  // stuck high fails falling check
    run_test(4, 0, 2, 1'b1, 1'b1, "R8");  // mid-test start and settle change
    run_test(0, 0, 3, 1'b0, 1'b1, "R7");
    run_test(1, 0, 2, 1'b1, 1'b0, "R5");  // back-to-back with previous
    run_test(255, 0, 4, 1'b1, 1'b0, "R2"); // largest settle value
    repeat (5) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule